// File: doc/BRIEF.md
# Gated Pulse-Count Acceleration Sampler

This block turns a pulse-density stream from a sensor into one signed acceleration sample per gate interval. The sensor raises its pulse line more often as acceleration grows. The pulse line arrives with no fixed timing relation to the system clock, so the block first synchronises it and then detects each rising edge. A free-running counter adds one for every edge and wraps at its width. It is never cleared.

A system-side timer pulses the sample strobe once per gate interval. At each strobe the block captures the counter and takes the difference from the previous capture, modulo the counter width, so a wrap between two strobes gives the right answer. It then subtracts a programmable zero-g count and registers the result as a two's-complement value one bit wider than the counter, together with a one-cycle valid flag. The difference is zero at negative full scale, about half the number of sensor clocks per gate at zero g, and equal to that number at positive full scale. A longer gate gives a finer step (the span times the sample rate over the sensor clock rate) but less bandwidth.

The sequencing is a two-state machine:
- `PH_PRIME` is entered at reset. A strobe in this state only loads the capture register, and the machine moves to `PH_TRACK` (transition "prime").
- In `PH_TRACK`, each strobe updates the capture register and publishes a sample. The machine stays in `PH_TRACK` (transition "publish").
- With no strobe, both states hold (transition "idle").

Top module: `pcs_sampler`

## Requirements
- R1: While reset is asserted and after it is released, `accel_valid` is 0 and `accel_value` is 0 until the first published sample.
- R2: Each rising edge of `pulse_in` adds exactly one to the internal count. A level held high for many cycles still counts once. The count never advances by more than one per clock.
- R3: The first strobe after reset produces no valid pulse. It only establishes the reference capture.
- R4: `accel_valid` is high for exactly the one clock cycle that follows the clock edge at which `sample_strobe` was sampled high (from the second strobe on). It is never high otherwise.
- R5: The interval difference equals the number of rising edges counted between two strobes, computed modulo 2^CNT_W. It stays correct when the counter wraps during the interval, provided fewer than 2^CNT_W edges occur.
- R6: `accel_value` equals the interval difference minus `zero_offset` (zero-extended), as a CNT_W+1-bit two's-complement number.
- R7: `accel_value` holds its value in every cycle in which `accel_valid` is low.
- R8: The extreme results are represented without overflow. A difference of 0 with an offset of 2^CNT_W-1 gives -(2^CNT_W-1). A difference of 2^CNT_W-1 with an offset of 0 gives +(2^CNT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Pulse-density stream from the sensor, asynchronous to clk |
| sample_strobe | input | 1 | One-cycle gate-interval strobe |
| zero_offset | input | CNT_W | Difference count that corresponds to zero acceleration |
| accel_value | output | CNT_W+1 | Signed acceleration count (two's complement) |
| accel_valid | output | 1 | One-cycle flag marking a new `accel_value` |

## Verification
The bench runs the count through a counter wrap many times. A design that subtracted without modular handling would then report large negative or garbage samples. The first strobe after reset is checked for silence, because a design that published there would emit a sample measured against a zero reference. A pulse held high for many cycles must count once; a level-sensitive counter would show a huge difference instead. The bench also drives the all-zero and all-ones difference against the maximum and zero offsets, so that a result register only CNT_W bits wide shows up as a sign error.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [0:0] {
        PH_PRIME = 1'b0,
        PH_TRACK = 1'b1
    } phase_t;

    localparam int unsigned PCS_DEF_CNT_W  = 8;
    localparam int unsigned PCS_DEF_SYNC_N = 2;

endpackage

// File: rtl/pcs_edge_sync.sv
module pcs_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pcs_pulse_counter.sv
module pcs_pulse_counter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (step) count <= count + ONE;
    end
endmodule

// File: rtl/pcs_delta_unit.sv
module pcs_delta_unit #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]      now_cnt,
    input  logic [WIDTH-1:0]      ref_cnt,
    input  logic [WIDTH-1:0]      offset,
    output logic signed [WIDTH:0] result
);
    localparam int unsigned OUT_W = WIDTH + 1;

    logic [WIDTH-1:0] span;
    logic [OUT_W-1:0] span_x;
    logic [OUT_W-1:0] off_x;

    always_comb begin
        span   = now_cnt - ref_cnt;          // modular: wrap-safe
        span_x = {1'b0, span};
        off_x  = {1'b0, offset};
        result = $signed(span_x - off_x);
    end
endmodule

// File: rtl/pcs_sampler.sv
module pcs_sampler
    import pcs_pkg::*;
#(
    parameter int unsigned CNT_W  = PCS_DEF_CNT_W,
    parameter int unsigned SYNC_N = PCS_DEF_SYNC_N
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pulse_in,
    input  logic                    sample_strobe,
    input  logic [CNT_W-1:0]        zero_offset,
    output logic signed [CNT_W:0]   accel_value,
    output logic                    accel_valid
);
    localparam int unsigned OUT_W = CNT_W + 1;

    logic                    edge_seen;
    logic [CNT_W-1:0]        count_w;
    logic [CNT_W-1:0]        ref_q;
    logic signed [OUT_W-1:0] next_value;
    phase_t                  phase_q, phase_d;

    pcs_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pulse_in),
        .rise     (edge_seen)
    );

    pcs_pulse_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (edge_seen),
        .count (count_w)
    );

    pcs_delta_unit #(.WIDTH(CNT_W)) u_delta (
        .now_cnt (count_w),
        .ref_cnt (ref_q),
        .offset  (zero_offset),
        .result  (next_value)
    );

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_PRIME: if (sample_strobe) phase_d = PH_TRACK;
            PH_TRACK: phase_d = PH_TRACK;
            default:  phase_d = PH_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_PRIME;
        else        phase_q <= phase_d;
    end

    // output / datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q       <= '0;
            accel_value <= '0;
            accel_valid <= 1'b0;
        end else begin
            accel_valid <= 1'b0;
            unique case (phase_q)
                PH_PRIME: begin
                    if (sample_strobe) ref_q <= count_w;
                end
                PH_TRACK: begin
                    if (sample_strobe) begin
                        ref_q       <= count_w;
                        accel_value <= next_value;
                        accel_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcs_sampler_chk.sv
module pcs_sampler_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  strobe,
    input logic                  valid,
    input logic signed [CNT_W:0] accel,
    input logic [CNT_W-1:0]      count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic primed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      primed_q <= 1'b0;
        else if (strobe) primed_q <= 1'b1;
    end

    // R2: the count moves by zero or one per clock
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + ONE));

    // R3: the priming strobe publishes nothing
    assert_prime_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !primed_q) |=> !valid);

    // R4: valid only follows a strobe
    assert_valid_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(strobe));

    // R4: a primed strobe always publishes
    assert_valid_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && primed_q) |=> valid);

    // R7: the result holds between samples
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(accel));
endmodule

bind pcs_sampler pcs_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (sample_strobe),
    .valid  (accel_valid),
    .accel  (accel_value),
    .count  (count_w)
);

// File: tb/pcs_sampler_test.sv
module pcs_sampler_test;
    localparam int unsigned W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                pulse_in = 1'b0;
    logic                sample_strobe = 1'b0;
    logic [W-1:0]        zero_offset = '0;
    logic signed [W:0]   accel_value;
    logic                accel_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcs_sampler #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in),
        .sample_strobe(sample_strobe), .zero_offset(zero_offset),
        .accel_value(accel_value), .accel_valid(accel_valid)
    );

    function automatic int expect_val(int edges, int off);
        return (edges % (MAXV + 1)) - off;
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulses(int n, int high_len);
        for (int i = 0; i < n; i++) begin
            pulse_in = 1'b1;
            repeat (high_len) @(negedge clk);
            pulse_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // strobe and verify a published sample
    task automatic gate(int edges, string req);
        int held;
        repeat (6) @(negedge clk);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
        check("R4 valid after strobe", int'(accel_valid), 1);
        check(req, int'(accel_value), expect_val(edges, int'(zero_offset)));
        held = int'(accel_value);
        @(negedge clk);
        check("R4 single-cycle valid", int'(accel_valid), 0);
        repeat (3) @(negedge clk);
        check("R7 hold", int'(accel_value), held);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(accel_valid), 0);
        check("R1 reset value", int'(accel_value), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle value", int'(accel_value), 0);

        pulses(5, 2);
        repeat (6) @(negedge clk);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
        check("R3 prime silent", int'(accel_valid), 0);
        @(negedge clk);
        check("R3 prime silent later", int'(accel_valid), 0);

        zero_offset = 8'd0;
        pulses(1, 20);
        gate(1, "R2 long level counts once");

        pulses(0, 2);
        gate(0, "R5 empty interval");

        zero_offset = 8'(MAXV);
        gate(0, "R8 minimum result");

        zero_offset = 8'd0;
        pulses(MAXV, 2);
        gate(MAXV, "R8 maximum result");

        zero_offset = 8'd128;
        pulses(128, 2);
        gate(128, "R6 zero-g result");

        for (int k = 0; k < 30; k++) begin
            int n;
            n = int'($urandom_range(MAXV, 0));
            zero_offset = 8'($urandom_range(MAXV, 0));
            pulses(n, 1 + int'($urandom_range(2, 0)));
            gate(n, "R5 R6 random interval with wrap");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule